// File: doc/BRIEF.md
# Lowest-Priority Interrupt Router

This block takes device interrupt messages, one at a time, and hands each one to one or more processor cores. Every message carries an interrupt vector and a delivery mode. A message can target one named core, all cores at once, or the core that is least busy. A core counts as least busy when its task priority value is smallest. Each core drives its current task priority into the router. The router compares those values when a lowest-priority message arrives, so the work spreads across cores as their load changes.

When more than one core shares the smallest task priority, a rotating pointer settles the choice. The pointer moves past the winner, so repeated ties walk through the tied cores in turn. Each delivered interrupt is shown to its cores as a per-core valid line plus a shared vector bus. The message stays posted until every core it addressed has accepted it. Only then does the router take the next message. A message it cannot deliver is dropped and reported on a one-cycle error pulse.

Top module: `lpr_router`

## Requirements
- R1: After a synchronous active-low reset, `irq_valid` is all zero, `msg_ready` is 1, `route_err` is 0 and the rotating pointer is at core 0.
- R2: A message with `msg_mode` = 0 (fixed) and `msg_dest` below 4 raises `irq_valid` only on core `msg_dest`, in the cycle after the clock edge where `msg_valid` and `msg_ready` are both high.
- R3: A message with `msg_mode` = 1 (broadcast) raises `irq_valid` on all four cores in the cycle after acceptance.
- R4: A message with `msg_mode` = 2 (lowest priority) raises `irq_valid` on exactly one core, and that core's task priority (field `core_tpr[4*i+3:4*i]` for core i, sampled at acceptance) is the smallest of all cores.
- R5: When several cores share the smallest task priority, the router picks the first tied core at or after the rotating pointer, scanning upward in index order and wrapping from core 3 to core 0.
- R6: The pointer moves to the core just after the winner, wrapping at 3, only when a tie was resolved. A lowest-priority message with a single smallest core, and any fixed or broadcast message, leaves the pointer unchanged.
- R7: Each core's `irq_valid` stays high until that core raises `core_accept`, and drops in the cycle after the accept. `msg_ready` stays low while any addressed core has not yet accepted.
- R8: A fixed message with `msg_dest` of 4 or more, or a message with the reserved `msg_mode` = 3, is dropped. `route_err` is high for exactly the one cycle after acceptance, no `irq_valid` rises, and `msg_ready` stays high.
- R9: `irq_vector` equals the accepted message's `msg_vector` and holds steady for as long as any `irq_valid` bit of that message is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Router can take a message this cycle |
| msg_mode | input | 2 | Delivery mode: 0 fixed, 1 broadcast, 2 lowest priority, 3 reserved |
| msg_dest | input | 3 | Destination core index for fixed mode |
| msg_vector | input | 8 | Interrupt vector of the message |
| core_tpr | input | 16 | Task priority of each core, 4 bits per core, core 0 in the low bits |
| irq_valid | output | 4 | Per-core interrupt pending toward the core |
| irq_vector | output | 8 | Vector of the posted interrupt |
| core_accept | input | 4 | Per-core accept of the posted interrupt |
| route_err | output | 1 | One-cycle pulse when a message was dropped |

## Verification
The bench targets the rotating tie-break. It runs a series of all-equal and partly-equal priority sets, with a single-minimum message placed between two ties. A pointer that moved on every lowest-priority message, or never moved, would pick the wrong core on the later tie. It also checks partial accepts. A router that released the whole message on the first accept, or took a new message early, would show valid lines dropping too soon or `msg_ready` rising too soon. It sends destination indices just past the last core and the reserved mode. A router that wrapped the index or truncated it to two bits would post the interrupt to core 0 or core 3 instead of raising `route_err`.

// File: rtl/lpr_pkg.sv
// Package: shared delivery-mode encoding for the interrupt router.
// Assumes a 2-bit mode field on the incoming message.
package lpr_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_BCAST  = 2'd1,
        MODE_LOWPRI = 2'd2,
        MODE_RSVD   = 2'd3
    } dmode_e;
endpackage

// File: rtl/lpr_min_finder.sv
// Module: finds the smallest task priority among all cores and flags
// every core that holds it. Also reports whether more than one core ties.
// Assumes: purely combinational, core i occupies bits [i*TPR_W +: TPR_W].
module lpr_min_finder #(
    parameter int NUM_CORES = 4,
    parameter int TPR_W     = 4
) (
    input  logic [NUM_CORES*TPR_W-1:0] tpr_flat,
    output logic [TPR_W-1:0]           min_tpr,
    output logic [NUM_CORES-1:0]       tie_mask,
    output logic                       multi_tie
);
    // Minimum search, then equality mask and tie count.
    always_comb begin
        min_tpr = '1;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (tpr_flat[i*TPR_W +: TPR_W] < min_tpr)
                min_tpr = tpr_flat[i*TPR_W +: TPR_W];
        end
        tie_mask = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            tie_mask[i] = (tpr_flat[i*TPR_W +: TPR_W] == min_tpr);
        end
        multi_tie = ($countones(tie_mask) > 1);
    end
endmodule

// File: rtl/lpr_rr_pick.sv
// Module: rotating picker. Grants the first requesting core found when
// scanning upward from the pointer, wrapping past the last core.
// Assumes: combinational; ptr < NUM_CORES; a zero request gives a zero grant.
module lpr_rr_pick #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_CORES-1:0] req,
    input  logic [IDX_W-1:0]     ptr,
    output logic [NUM_CORES-1:0] grant,
    output logic [IDX_W-1:0]     grant_idx
);
    int   idx;
    logic found;

    // Wrapping scan from the pointer position.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        idx       = 0;
        for (int off = 0; off < NUM_CORES; off++) begin
            idx = (int'(ptr) + off) % NUM_CORES;
            if (!found && req[idx]) begin
                found     = 1'b1;
                grant[idx] = 1'b1;
                grant_idx = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/lpr_delivery.sv
// Module: holds the posted interrupt. A load captures the target mask
// and vector. Each core's pending bit clears on that core's accept.
// Assumes: the parent loads only while nothing is pending.
module lpr_delivery #(
    parameter int NUM_CORES = 4,
    parameter int VEC_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_CORES-1:0] load_mask,
    input  logic [VEC_W-1:0]     load_vec,
    input  logic [NUM_CORES-1:0] accept,
    output logic [NUM_CORES-1:0] pend,
    output logic [VEC_W-1:0]     vec
);
    // Capture a new message or retire accepted cores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            vec  <= '0;
        end else if (load) begin
            pend <= load_mask;
            vec  <= load_vec;
        end else begin
            pend <= pend & ~accept;
        end
    end
endmodule

// File: rtl/lpr_router.sv
// Module: top of the interrupt router. Decodes the delivery mode, picks
// the least-busy core with rotating fairness among ties, posts the
// interrupt and waits for all addressed cores to accept it.
// Assumes: DEST_W is wide enough to express indices >= NUM_CORES;
// task priorities are sampled in the acceptance cycle.
module lpr_router
    import lpr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TPR_W     = 4,
    parameter int VEC_W     = 8,
    parameter int DEST_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    output logic                       msg_ready,
    input  logic [1:0]                 msg_mode,
    input  logic [DEST_W-1:0]          msg_dest,
    input  logic [VEC_W-1:0]           msg_vector,
    input  logic [NUM_CORES*TPR_W-1:0] core_tpr,
    output logic [NUM_CORES-1:0]       irq_valid,
    output logic [VEC_W-1:0]           irq_vector,
    input  logic [NUM_CORES-1:0]       core_accept,
    output logic                       route_err
);
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    dmode_e               mode;
    logic                 take;
    logic                 load;
    logic                 drop;
    logic [NUM_CORES-1:0] target;
    logic [TPR_W-1:0]     min_tpr;
    logic [NUM_CORES-1:0] tie_mask;
    logic                 multi_tie;
    logic [NUM_CORES-1:0] lp_grant;
    logic [IDX_W-1:0]     lp_idx;
    logic [IDX_W-1:0]     rr_ptr;
    logic [NUM_CORES-1:0] pend;

    assign mode = dmode_e'(msg_mode);

    lpr_min_finder #(.NUM_CORES(NUM_CORES), .TPR_W(TPR_W)) i_min (
        .tpr_flat (core_tpr),
        .min_tpr  (min_tpr),
        .tie_mask (tie_mask),
        .multi_tie(multi_tie)
    );

    lpr_rr_pick #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) i_pick (
        .req      (tie_mask),
        .ptr      (rr_ptr),
        .grant    (lp_grant),
        .grant_idx(lp_idx)
    );

    // Target mask from the delivery mode and destination.
    always_comb begin
        target = '0;
        case (mode)
            MODE_FIXED: begin
                if (msg_dest < DEST_W'(NUM_CORES))
                    target[msg_dest[IDX_W-1:0]] = 1'b1;
            end
            MODE_BCAST:  target = '1;
            MODE_LOWPRI: target = lp_grant;
            default:     target = '0;
        endcase
    end

    assign msg_ready = (pend == '0);
    assign take      = msg_valid && msg_ready;
    assign load      = take && (target != '0);
    assign drop      = take && (target == '0);

    lpr_delivery #(.NUM_CORES(NUM_CORES), .VEC_W(VEC_W)) i_dlv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_mask(target),
        .load_vec (msg_vector),
        .accept   (core_accept),
        .pend     (pend),
        .vec      (irq_vector)
    );

    assign irq_valid = pend;

    // Rotating pointer advances past the winner only when a tie was broken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (take && mode == MODE_LOWPRI && multi_tie)
            rr_ptr <= (lp_idx == IDX_W'(NUM_CORES - 1)) ? '0 : lp_idx + 1'b1;
    end

    // One-cycle error pulse for a dropped message.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_err <= 1'b0;
        else
            route_err <= drop;
    end

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == MODE_BCAST |=> (&irq_valid)); // R3
    AST_LOWPRI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == MODE_LOWPRI |=> $onehot(irq_valid)); // R4
    AST_LOWPRI_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode == MODE_LOWPRI |=> ((irq_valid & ~$past(tie_mask)) == '0)); // R4
    AST_HOLD_UNTIL_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_ready |=> ((irq_valid & $past(irq_valid & ~core_accept))
                        == $past(irq_valid & ~core_accept))); // R7
    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_ready |=> (irq_valid == '0) || $stable(irq_vector)); // R9
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> route_err && (irq_valid == '0)); // R8
endmodule

// File: tb/test_lpr_router.sv
`timescale 1ns/1ps
module test_lpr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic        msg_ready;
    logic [1:0]  msg_mode = 2'd0;
    logic [2:0]  msg_dest = 3'd0;
    logic [7:0]  msg_vector = 8'd0;
    logic [15:0] core_tpr = 16'd0;
    logic [3:0]  irq_valid;
    logic [7:0]  irq_vector;
    logic [3:0]  core_accept = 4'd0;
    logic        route_err;

    int checks = 0;
    int errors = 0;
    int exp_ptr = 0;
    int tp[4];
    logic seen = 1'b0;

    typedef struct {
        logic [3:0] mask;
        logic [7:0] vec;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    lpr_router i_lpr_router (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_mode(msg_mode), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .core_tpr(core_tpr), .irq_valid(irq_valid), .irq_vector(irq_vector),
        .core_accept(core_accept), .route_err(route_err)
    );

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic set_tpr(int t0, int t1, int t2, int t3);
        tp[0] = t0; tp[1] = t1; tp[2] = t2; tp[3] = t3;
        core_tpr = {4'(t3), 4'(t2), 4'(t1), 4'(t0)};
    endtask

    // Monitor: pops the scoreboard when a new message appears on the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq_valid != 4'd0 && !seen) begin
                seen = 1'b1;
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2: unexpected delivery actual=%0h expected=none", irq_valid);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.req, " mask"}, 32'(irq_valid), 32'(e.mask));
                    chk("R9 vector", 32'(irq_vector), 32'(e.vec));
                end
            end else if (irq_valid == 4'd0) begin
                seen = 1'b0;
            end
        end
    end

    // Driver: computes the expected target, sends, then runs accepts.
    task automatic send(int mode, int dest, logic [7:0] vec, bit stagger);
        logic [3:0] m;
        string r;
        m = 4'd0;
        if (mode == 0) begin
            r = "R2";
            if (dest < 4) m[dest] = 1'b1;
            else r = "R8";
        end else if (mode == 1) begin
            r = "R3"; m = 4'hF;
        end else if (mode == 2) begin
            int mn; int cnt; int pick;
            r = "R4"; mn = 99; cnt = 0; pick = 0;
            for (int i = 0; i < 4; i++) if (tp[i] < mn) mn = tp[i];
            for (int i = 0; i < 4; i++) if (tp[i] == mn) cnt++;
            if (cnt == 1) begin
                for (int i = 0; i < 4; i++) if (tp[i] == mn) pick = i;
            end else begin
                r = "R5";
                for (int off = 3; off >= 0; off--)
                    if (tp[(exp_ptr + off) % 4] == mn) pick = (exp_ptr + off) % 4;
                exp_ptr = (pick + 1) % 4;
            end
            m[pick] = 1'b1;
        end else begin
            r = "R8";
        end
        if (m != 4'd0) sb.push_back('{m, vec, r});

        @(negedge clk);
        msg_valid = 1'b1; msg_mode = 2'(mode); msg_dest = 3'(dest); msg_vector = vec;
        @(posedge clk);
        @(negedge clk);
        msg_valid = 1'b0;
        if (m == 4'd0) begin
            chk("R8 err pulse", 32'(route_err), 32'd1);
            chk("R8 no delivery", 32'(irq_valid), 32'd0);
            chk("R8 ready kept", 32'(msg_ready), 32'd1);
            @(negedge clk);
            chk("R8 err one cycle", 32'(route_err), 32'd0);
            return;
        end
        chk("R7 ready low", 32'(msg_ready), 32'd0);
        repeat (2) @(negedge clk);
        chk("R7 held", 32'(irq_valid), 32'(m));
        if (stagger) begin
            logic [3:0] rem;
            rem = m;
            for (int i = 0; i < 4; i++) begin
                if (m[i]) begin
                    core_accept = 4'd0; core_accept[i] = 1'b1;
                    @(negedge clk);
                    core_accept = 4'd0;
                    rem[i] = 1'b0;
                    chk("R7 partial", 32'(irq_valid), 32'(rem));
                    chk("R7 ready", 32'(msg_ready), 32'(rem == 4'd0));
                    if (rem != 4'd0) chk("R9 vec hold", 32'(irq_vector), 32'(vec));
                end
            end
        end else begin
            core_accept = m;
            @(negedge clk);
            core_accept = 4'd0;
            chk("R7 cleared", 32'(irq_valid), 32'd0);
            chk("R7 ready back", 32'(msg_ready), 32'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        set_tpr(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(irq_valid), 32'd0);
        chk("R1 ready", 32'(msg_ready), 32'd1);
        chk("R1 err", 32'(route_err), 32'd0);

        send(0, 2, 8'h31, 1'b0);          // R2 fixed
        send(0, 0, 8'h32, 1'b0);          // R2 fixed core 0
        send(1, 0, 8'h80, 1'b1);          // R3 broadcast, R7 staggered, R9
        set_tpr(5, 3, 7, 9);
        send(2, 0, 8'h40, 1'b0);          // R4 unique min -> core 1
        set_tpr(4, 4, 4, 4);
        send(2, 0, 8'h41, 1'b0);          // R5 tie -> core 0
        send(2, 0, 8'h42, 1'b0);          // R5 tie -> core 1
        set_tpr(2, 9, 9, 2);
        send(2, 0, 8'h43, 1'b0);          // R5 wrap -> core 3
        set_tpr(8, 8, 1, 8);
        send(2, 0, 8'h44, 1'b0);          // R6 unique -> core 2, pointer kept
        set_tpr(6, 6, 6, 6);
        send(2, 0, 8'h45, 1'b0);          // R6 pointer unmoved -> core 0
        send(0, 4, 8'h50, 1'b0);          // R8 just out of range
        send(0, 7, 8'h51, 1'b0);          // R8 top index
        send(3, 0, 8'h52, 1'b0);          // R8 reserved mode
        send(0, 3, 8'h53, 1'b1);          // R2 after drops
        send(2, 0, 8'h54, 1'b0);          // R6 drops left pointer -> core 1
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule